// File: doc/BRIEF.md
# Two-Stage Real-Time-Clock Prescaler

This block turns a slow enable at the real-time-clock rate into two slower enables. The first stage divides the incoming enable by one more than a 7-bit coefficient. The second stage divides the first stage's output by one more than a 15-bit coefficient. Both stages are down-counters. Each counter emits a single-cycle pulse when it reaches zero and reloads its coefficient at that point. Everything runs in one clock domain, and the incoming enable is a one-cycle strobe.

Both coefficients sit in one 32-bit control word. Software changes the word only while the init-mode input is high and the write-protect-unlocked input is true. During init mode the dividers are frozen. When init mode ends, a one-cycle reload state loads both counters from the stored coefficients, so the first output period after leaving init mode is exact.

The controller has three states. LOAD is entered from reset and from HOLD, and reloads both counters. RUN counts. HOLD freezes the counters while init mode is high. The transitions are:
- LOAD to RUN when init mode is low.
- LOAD to HOLD when init mode is high.
- RUN to HOLD when init mode rises.
- HOLD to LOAD when init mode falls.

Top module: `rtc_prescaler`

## Requirements
- R1: After reset the control word reads 0x007F00FF, so the first-stage coefficient is 0x7F and the second-stage coefficient is 0x00FF.
- R2: The second-stage coefficient occupies control-word bits 14:0 and the first-stage coefficient occupies bits 22:16; a written value reads back in those positions.
- R3: Bit 15 and bits 31:23 of the control word always read as zero, whatever data was written to them.
- R4: A write takes effect only when `cfg_wr`, `init_mode` and `wp_unlocked` are all high in the same cycle; any other write is ignored and the old value is kept.
- R5: In RUN, `apre_tick` is high in the same cycle as every (A+1)-th `rtc_tick`, where A is the first-stage coefficient, and is never high without `rtc_tick`.
- R6: `spre_tick` is high in the same cycle as every (S+1)-th `apre_tick`, where S is the second-stage coefficient, and is never high without `apre_tick`.
- R7: While `init_mode` is high, and from the cycle after it rises, neither tick output is asserted and both counters keep their values.
- R8: When `init_mode` falls, the block spends exactly one cycle in LOAD, where an `rtc_tick` is ignored. From RUN, the first `apre_tick` falls on the (A+1)-th `rtc_tick`, even if init mode interrupted a partly counted period.
- R9: A coefficient of zero makes its stage pass every input enable straight through as an output tick.
- R10: Reset enters LOAD, and the first clock edge after reset is released moves to RUN with both counters loaded from the reset defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rtc_tick | input | 1 | One-cycle enable at the real-time-clock rate |
| init_mode | input | 1 | High while initialisation mode is active; freezes the dividers |
| wp_unlocked | input | 1 | High when write protection has been released |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Data for the control word |
| cfg_rdata | output | 32 | Current control word, reserved bits zero |
| apre_tick | output | 1 | First-stage output enable |
| spre_tick | output | 1 | Second-stage output enable |

## Verification
The tick outputs are combinational from the counters and the controller state. Each tick is due in the same cycle as the `rtc_tick` that completes its period, so the bench drives `rtc_tick` on a falling edge and samples both ticks one nanosecond later. The bench also checks the cycle that follows each `rtc_tick` and expects both ticks low there.

A control-word write lands on the rising edge that samples `cfg_wr`, and the readback is compared on the next falling edge. Leaving init mode takes two rising edges, HOLD to LOAD and then LOAD to RUN. The bench drives a stray `rtc_tick` in the LOAD cycle and expects no tick. It then counts tick indices from the first RUN cycle. The expected pulse positions are computed as modulo arithmetic on the tick index, over a sweep of small coefficient pairs and over the full reset-default period.

// File: rtl/rtc_psc_pkg.sv
package rtc_psc_pkg;

    localparam int CFG_W    = 32;
    localparam int SPSC_W   = 15;
    localparam int APSC_W   = 7;
    localparam int SPSC_LSB = 0;
    localparam int APSC_LSB = 16;

    localparam logic [SPSC_W-1:0] SPSC_RST = SPSC_W'(16'h00FF);
    localparam logic [APSC_W-1:0] APSC_RST = APSC_W'(8'h7F);

    typedef enum logic [1:0] {
        PS_LOAD = 2'd0,
        PS_RUN  = 2'd1,
        PS_HOLD = 2'd2
    } ps_state_t;

endpackage

// File: rtl/rtc_psc_ctrl.sv
module rtc_psc_ctrl
    import rtc_psc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic init_mode,
    output logic load,
    output logic run
);

    ps_state_t state_q;
    ps_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_LOAD: state_d = init_mode ? PS_HOLD : PS_RUN;
            PS_RUN:  state_d = init_mode ? PS_HOLD : PS_RUN;
            PS_HOLD: state_d = init_mode ? PS_HOLD : PS_LOAD;
            default: state_d = PS_LOAD;
        endcase
    end

    always_comb begin
        load = 1'b0;
        run  = 1'b0;
        unique case (state_q)
            PS_LOAD: load = 1'b1;
            PS_RUN:  run  = 1'b1;
            PS_HOLD: ;
            default: load = 1'b1;
        endcase
    end

    // R8: every exit from HOLD passes through LOAD
    a_r8_hold_exits_via_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_HOLD && !init_mode) |=> (state_q == PS_LOAD));

    // R7: init mode always lands in HOLD on the next edge
    a_r7_init_enters_hold: assert property (@(posedge clk) disable iff (!rst_n)
        init_mode |=> (state_q == PS_HOLD));

endmodule

// File: rtl/rtc_psc_regs.sv
module rtc_psc_regs
    import rtc_psc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              init_mode,
    input  logic              wp_unlocked,
    input  logic [CFG_W-1:0]  wdata,
    output logic [SPSC_W-1:0] spsc,
    output logic [APSC_W-1:0] apsc,
    output logic [CFG_W-1:0]  rdata
);

    logic wr_ok;

    assign wr_ok = wr_req && init_mode && wp_unlocked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spsc <= SPSC_RST;
            apsc <= APSC_RST;
        end else if (wr_ok) begin
            spsc <= wdata[SPSC_LSB +: SPSC_W];
            apsc <= wdata[APSC_LSB +: APSC_W];
        end
    end

    always_comb begin
        rdata = '0;
        rdata[SPSC_LSB +: SPSC_W] = spsc;
        rdata[APSC_LSB +: APSC_W] = apsc;
    end

    // R4: a write missing any enable leaves the coefficients untouched
    a_r4_gated_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req && init_mode && wp_unlocked) |=> ($stable(spsc) && $stable(apsc)));

    // R4: the coefficients only change while init mode is active
    a_r4_no_change_outside_init: assert property (@(posedge clk) disable iff (!rst_n)
        !init_mode |=> $stable(rdata));

endmodule

// File: rtl/rtc_psc_stage.sv
module rtc_psc_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         en,
    input  logic [W-1:0] coef,
    output logic         tick
);

    logic [W-1:0] cnt_q;
    logic         at_zero;

    assign at_zero = (cnt_q == '0);
    assign tick    = en && at_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= coef;
        end else if (en) begin
            if (at_zero) begin
                cnt_q <= coef;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R8: a load cycle leaves the counter at the coefficient
    a_r8_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(coef)));

    // R5: an enabled nonzero counter steps down by one
    a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && cnt_q != '0) |=> (cnt_q == W'($past(cnt_q) - 1'b1)));

    // R7: without enable or load the counter holds
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(cnt_q));

    // R5: a tick never appears without an input enable
    a_r5_tick_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> en);

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_psc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rtc_tick,
    input  logic             init_mode,
    input  logic             wp_unlocked,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             apre_tick,
    output logic             spre_tick
);

    logic              load;
    logic              run;
    logic [SPSC_W-1:0] spsc;
    logic [APSC_W-1:0] apsc;
    logic              a_en;

    rtc_psc_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_mode (init_mode),
        .load      (load),
        .run       (run)
    );

    rtc_psc_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_req      (cfg_wr),
        .init_mode   (init_mode),
        .wp_unlocked (wp_unlocked),
        .wdata       (cfg_wdata),
        .spsc        (spsc),
        .apsc        (apsc),
        .rdata       (cfg_rdata)
    );

    assign a_en = run && rtc_tick;

    rtc_psc_stage #(.W(APSC_W)) u_astage (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .en    (a_en),
        .coef  (apsc),
        .tick  (apre_tick)
    );

    rtc_psc_stage #(.W(SPSC_W)) u_sstage (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .en    (apre_tick),
        .coef  (spsc),
        .tick  (spre_tick)
    );

    // R6: second stage only fires together with the first
    a_r6_spre_with_apre: assert property (@(posedge clk) disable iff (!rst_n)
        spre_tick |-> apre_tick);

    // R5: first stage only fires on an input enable
    a_r5_apre_with_input: assert property (@(posedge clk) disable iff (!rst_n)
        apre_tick |-> rtc_tick);

    // R7: no output activity in the cycle after init mode is seen
    a_r7_quiet_in_init: assert property (@(posedge clk) disable iff (!rst_n)
        init_mode |=> (!apre_tick && !spre_tick));

    // R8: the cycle after init mode falls is the reload cycle, with no ticks
    a_r8_quiet_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_mode) |=> (!apre_tick && !spre_tick));

    // R3: reserved fields never carry data
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[15] == 1'b0) && (cfg_rdata[31:23] == 9'd0));

endmodule

// File: tb/rtc_prescaler_bench.sv
`timescale 1ns/1ps
module rtc_prescaler_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rtc_tick = 1'b0;
    logic        init_mode = 1'b0;
    logic        wp_unlocked = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        apre_tick;
    logic        spre_tick;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rtc_prescaler u_rtc_prescaler (
        .clk         (clk),
        .rst_n       (rst_n),
        .rtc_tick    (rtc_tick),
        .init_mode   (init_mode),
        .wp_unlocked (wp_unlocked),
        .cfg_wr      (cfg_wr),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .apre_tick   (apre_tick),
        .spre_tick   (spre_tick)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] d, input bit en);
        @(negedge clk);
        cfg_wr = en;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        #1;
    endtask

    task automatic exit_init();
        @(negedge clk);
        init_mode = 1'b0;
        @(negedge clk);
        rtc_tick = 1'b1;
        #1;
        chk(apre_tick == 1'b0 && spre_tick == 1'b0, "R8 load cycle ignores rtc_tick",
            {30'd0, spre_tick, apre_tick}, 32'd0);
        @(negedge clk);
        rtc_tick = 1'b0;
    endtask

    task automatic drive_ticks(input int a, input int s, input int n, input bit gaps, input string req);
        for (int k = 1; k <= n; k++) begin
            bit ea;
            bit es;
            @(negedge clk);
            rtc_tick = 1'b1;
            #1;
            ea = (k % (a + 1)) == 0;
            es = (k % ((a + 1) * (s + 1))) == 0;
            chk(apre_tick == ea, {req, " apre"}, {31'd0, apre_tick}, {31'd0, ea});
            chk(spre_tick == es, {req, " spre"}, {31'd0, spre_tick}, {31'd0, es});
            if (gaps) begin
                @(negedge clk);
                rtc_tick = 1'b0;
                #1;
                chk(apre_tick == 1'b0 && spre_tick == 1'b0, {req, " idle cycle"},
                    {30'd0, spre_tick, apre_tick}, 32'd0);
            end
        end
        @(negedge clk);
        rtc_tick = 1'b0;
    endtask

    function automatic logic [31:0] cfg_word(input int a, input int s);
        return (32'(a) << 16) | 32'(s);
    endfunction

    initial begin
        #(8 * 190000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(cfg_rdata == 32'h007F00FF, "R1 reset word", cfg_rdata, 32'h007F00FF);
        rst_n = 1'b1;
        // R10: default period straight out of reset, full second-stage cycle
        drive_ticks(127, 255, 128 * 256, 1'b0, "R10 reset defaults");

        // R4: write without init mode is ignored
        wp_unlocked = 1'b1;
        write_cfg(32'h00010002, 1'b1);
        chk(cfg_rdata == 32'h007F00FF, "R4 write outside init", cfg_rdata, 32'h007F00FF);
        // R4: write while locked is ignored
        @(negedge clk);
        init_mode = 1'b1;
        wp_unlocked = 1'b0;
        write_cfg(32'h00010002, 1'b1);
        chk(cfg_rdata == 32'h007F00FF, "R4 write while locked", cfg_rdata, 32'h007F00FF);
        // R4: strobe low does nothing
        wp_unlocked = 1'b1;
        write_cfg(32'h00010002, 1'b0);
        chk(cfg_rdata == 32'h007F00FF, "R4 no strobe", cfg_rdata, 32'h007F00FF);
        // R2/R3: field placement and reserved bits
        write_cfg(32'hFFFFFFFF, 1'b1);
        chk(cfg_rdata == 32'h007F7FFF, "R3 reserved bits read zero", cfg_rdata, 32'h007F7FFF);
        write_cfg(32'hAA55AAAA, 1'b1);
        chk(cfg_rdata == 32'h00552AAA, "R2 field positions", cfg_rdata, 32'h00552AAA);
        write_cfg(32'h00000000, 1'b1);
        chk(cfg_rdata == 32'h00000000, "R2 zero word", cfg_rdata, 32'h00000000);
        exit_init();
        // R9: both coefficients zero pass every enable through
        drive_ticks(0, 0, 6, 1'b1, "R9 zero coefficients");

        // R5/R6: near-exhaustive sweep of small coefficient pairs
        for (int a = 0; a <= 4; a++) begin
            for (int s = 0; s <= 3; s++) begin
                @(negedge clk);
                init_mode = 1'b1;
                write_cfg(cfg_word(a, s), 1'b1);
                chk(cfg_rdata == cfg_word(a, s), "R2 sweep readback", cfg_rdata, cfg_word(a, s));
                exit_init();
                drive_ticks(a, s, 2 * (a + 1) * (s + 1), 1'b1, "R5 R6 sweep");
            end
        end

        // R8: interrupted period restarts in full
        @(negedge clk);
        init_mode = 1'b1;
        write_cfg(cfg_word(3, 1), 1'b1);
        exit_init();
        drive_ticks(3, 1, 2, 1'b1, "R8 partial period");
        @(negedge clk);
        init_mode = 1'b1;
        // R7: ticks during init mode produce nothing
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rtc_tick = 1'b1;
            #1;
            chk(apre_tick == 1'b0 && spre_tick == 1'b0, "R7 no ticks in init",
                {30'd0, spre_tick, apre_tick}, 32'd0);
        end
        @(negedge clk);
        rtc_tick = 1'b0;
        exit_init();
        drive_ticks(3, 1, 16, 1'b1, "R8 exact period after exit");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule